// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the purely combinational arithmetic unit of an 8-bit accumulator machine. It takes the accumulator, one operand byte, the current carry flag and the high nibble of the opcode. From these it produces:

- a result byte;
- a write strobe that says where the result goes;
- the new sign, signed-overflow, zero and carry flags;
- a mask that marks which flag bits the instruction changes.

The surrounding sequencer merges the masked flag bits into its status register and routes the result.

Four opcode groups are served. The bitwise group and the load group write the accumulator. The add/subtract group also writes the accumulator. The shift/rotate group works on the operand alone and sends its result back to where the operand came from. Left shifts reuse the adder by adding the operand to itself. Right shifts use a separate one-position path.

Opcode nibbles 0 to 3 belong to other units, including the store group. For these nibbles the block stays silent.

Top module: `acc_alu`

## Requirements
- R1: Nibble 8 gives acc AND operand, nibble 9 gives acc OR operand, and nibble A gives acc XOR operand.
- R2: Nibble B (load) returns the operand unchanged, whatever the accumulator holds.
- R3: Nibble C (ADD) returns acc + operand + 0, and nibble D (ADC) returns acc + operand + carry_i. The new carry is the adder's carry-out.
- R4: Nibble E (SUB) returns acc + ~operand + 1, and nibble F (SBC) returns acc + ~operand + carry_i. The new carry is the raw carry-out, so 1 means no borrow.
- R5: For nibbles C to F and 4 to 5, the overflow flag is set exactly when the signed (two's complement) result falls outside -128..127.
- R6: Nibble 4 (SHL) returns operand + operand + 0, and nibble 5 (ROL) returns operand + operand + carry_i. The new carry is the bit shifted out of bit 7.
- R7: Nibble 6 (SHR) shifts the operand right and keeps bit 7. Nibble 7 (ROR) shifts right and fills bit 7 from carry_i. For both, the new carry is operand bit 0 and overflow is result bit 7 XOR the new carry.
- R8: The flag vectors use bit 7 for minus, bit 6 for overflow, bit 1 for zero and bit 0 for carry. The mask is 8'h82 for nibbles 8 to B and 8'hC3 for nibbles 4 to 7 and C to F. flags_o is 0 wherever the mask is 0.
- R9: Wherever the mask allows, minus equals result bit 7 and zero is set exactly when the result is 0.
- R10: Nibbles 8 to F raise wr_acc_o only. Nibbles 4 to 7 raise wr_opnd_o only.
- R11: Nibbles 0 to 3 (including the store group) give result 0, no write strobe, mask 0 and flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte (register, accumulator, immediate, I/O or memory) |
| carry_i | input | 1 | Current carry flag |
| op_i | input | 4 | High opcode nibble |
| res_o | output | 8 | Result byte |
| wr_acc_o | output | 1 | Result is written to the accumulator |
| wr_opnd_o | output | 1 | Result is written back to the operand's location |
| flags_o | output | 8 | New flag values (bit 7 M, bit 6 O, bit 1 Z, bit 0 C) |
| flag_mask_o | output | 8 | Flag bits updated by this instruction |

## Verification
Every output is due in the same cycle as its inputs, because no register lies between any input and any output. The bench changes the inputs on the falling clock edge and compares all outputs one nanosecond later. That point is well clear of the next rising edge, so the comparison always sees settled combinational values. Random operands, carries and nibbles are mixed with directed cases at the carry, overflow and zero boundaries.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          carry_i,
  input  logic [3:0]    op_i,
  output logic [DW-1:0] res_o,
  output logic          wr_acc_o,
  output logic          wr_opnd_o,
  output logic [7:0]    flags_o,
  output logic [7:0]    flag_mask_o
);
  localparam int MSB = DW - 1;
  localparam logic [7:0] MASK_MZ   = 8'h82;
  localparam logic [7:0] MASK_MOZC = 8'hC3;

  wire acc_grp   = op_i[3];
  wire shf_grp   = (op_i[3:2] == 2'b01);
  wire logic_grp = acc_grp && !op_i[2];
  wire sum_grp   = acc_grp && op_i[2];
  wire rsh_grp   = shf_grp && op_i[1];

  logic [DW-1:0] add_a, add_b, sum;
  logic          add_ci, add_co;

  assign add_a  = acc_grp ? acc_i : opnd_i;
  assign add_b  = (acc_grp && op_i[1]) ? ~opnd_i : opnd_i;
  assign add_ci = op_i[0] ? carry_i : (acc_grp & op_i[1]);
  assign {add_co, sum} = {1'b0, add_a} + {1'b0, add_b} + {{DW{1'b0}}, add_ci};

  wire add_ov = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);

  logic [DW-1:0] logic_res, rsh_res;
  always_comb begin
    case (op_i[1:0])
      2'b00:   logic_res = acc_i & opnd_i;
      2'b01:   logic_res = acc_i | opnd_i;
      2'b10:   logic_res = acc_i ^ opnd_i;
      default: logic_res = opnd_i;
    endcase
  end

  assign rsh_res = {op_i[0] ? carry_i : opnd_i[MSB], opnd_i[MSB:1]};

  always_comb begin
    if (logic_grp)    res_o = logic_res;
    else if (rsh_grp) res_o = rsh_res;
    else if (sum_grp || shf_grp) res_o = sum;
    else              res_o = '0;
  end

  wire new_c = rsh_grp ? opnd_i[0] : add_co;
  wire new_o = rsh_grp ? (rsh_res[MSB] ^ opnd_i[0]) : add_ov;

  assign wr_acc_o    = acc_grp;
  assign wr_opnd_o   = shf_grp;
  assign flag_mask_o = logic_grp ? MASK_MZ : ((sum_grp || shf_grp) ? MASK_MOZC : 8'h00);
  assign flags_o     = flag_mask_o & {res_o[MSB], new_o, 4'b0000, (res_o == '0), new_c};

  always_comb begin
    if (op_i[3:2] == 2'b00)
      AST_SILENT_LOW: assert (flag_mask_o == 8'h00 && !wr_acc_o && !wr_opnd_o && flags_o == 8'h00); // R11
    if (wr_acc_o || wr_opnd_o)
      AST_ONE_DEST: assert (wr_acc_o != wr_opnd_o); // R10
    if (op_i == 4'hB)
      AST_LOAD_PASS: assert (res_o == opnd_i); // R2
    if (flag_mask_o[1])
      AST_ZERO_FLAG: assert (flags_o[1] == (res_o == '0)); // R9
    if (op_i == 4'h6)
      AST_SHR_SIGN: assert (res_o[MSB] == opnd_i[MSB] && flags_o[0] == opnd_i[0]); // R7
    AST_MASK_CLEAN: assert ((flags_o & ~flag_mask_o) == 8'h00); // R8
  end
endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/100ps
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc, opnd;
  logic       cin;
  logic [3:0] op;
  logic [7:0] res, flags, mask;
  logic       wa, wo;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  acc_alu i_acc_alu (
    .acc_i(acc), .opnd_i(opnd), .carry_i(cin), .op_i(op),
    .res_o(res), .wr_acc_o(wa), .wr_opnd_o(wo),
    .flags_o(flags), .flag_mask_o(mask)
  );

  function automatic logic [25:0] model(input logic [7:0] a, input logic [7:0] b,
                                        input logic c, input logic [3:0] o);
    int s, sv, ci;
    logic [7:0] r, m;
    logic co, ov, w_a, w_o;
    r = 0; co = 0; ov = 0; m = 0; w_a = 0; w_o = 0;
    if (o >= 4'h8 && o <= 4'hB) begin
      w_a = 1; m = 8'h82;
      case (o)
        4'h8: r = a & b;
        4'h9: r = a | b;
        4'hA: r = a ^ b;
        default: r = b;
      endcase
    end else if (o >= 4'hC) begin
      w_a = 1; m = 8'hC3;
      if (o == 4'hC) ci = 0; else if (o == 4'hE) ci = 1; else ci = int'(c);
      if (o <= 4'hD) begin
        s  = int'(a) + int'(b) + ci;
        sv = int'($signed(a)) + int'($signed(b)) + ci;
      end else begin
        s  = int'(a) + (255 - int'(b)) + ci;
        sv = int'($signed(a)) - int'($signed(b)) - (1 - ci);
      end
      r = s[7:0]; co = s > 255; ov = (sv > 127) || (sv < -128);
    end else if (o >= 4'h4) begin
      w_o = 1; m = 8'hC3;
      if (o <= 4'h5) begin
        ci = (o == 4'h5) ? int'(c) : 0;
        s  = 2 * int'(b) + ci;
        sv = 2 * int'($signed(b)) + ci;
        r = s[7:0]; co = s > 255; ov = (sv > 127) || (sv < -128);
      end else begin
        r = {(o == 4'h7) ? c : b[7], b[7:1]};
        co = b[0]; ov = r[7] ^ co;
      end
    end
    return {r, w_a, w_o, m & {r[7], ov, 4'b0, (r == 0), co}, m};
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'h8, 4'h9, 4'hA: return "R1";
      4'hB:             return "R2";
      4'hC, 4'hD:       return "R3";
      4'hE, 4'hF:       return "R4";
      4'h4, 4'h5:       return "R6";
      4'h6, 4'h7:       return "R7";
      default:          return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h acc=%h opnd=%h c=%b actual=%h expected=%h", req, op, acc, opnd, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c, input logic [3:0] o);
    logic [25:0] e;
    @(negedge clk);
    acc = a; opnd = b; cin = c; op = o;
    #1;
    e = model(a, b, c, o);
    check(tag(o), {24'b0, res}, {24'b0, e[25:18]});
    check("R10", {30'b0, wa, wo}, {30'b0, e[17:16]});
    check("R8", {24'b0, mask}, {24'b0, e[7:0]});
    if (o >= 4'hC || (o >= 4'h4 && o <= 4'h5))
      check("R5", {31'b0, flags[6]}, {31'b0, e[14]});
    check("R9", {24'b0, flags}, {24'b0, e[15:8]});
  endtask

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    acc = 0; opnd = 0; cin = 0; op = 0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R11", {6'b0, res, wa, wo, flags, mask}, 32'h0);
    apply(8'h7F, 8'h01, 1'b0, 4'hC);
    apply(8'hFF, 8'h01, 1'b0, 4'hC);
    apply(8'hFF, 8'h00, 1'b1, 4'hD);
    apply(8'h80, 8'h01, 1'b0, 4'hE);
    apply(8'h00, 8'h01, 1'b1, 4'hE);
    apply(8'h05, 8'h05, 1'b0, 4'hF);
    apply(8'h05, 8'h05, 1'b1, 4'hF);
    apply(8'hAA, 8'h3C, 1'b1, 4'hB);
    apply(8'hF0, 8'h0F, 1'b0, 4'h8);
    apply(8'hF0, 8'h0F, 1'b0, 4'h9);
    apply(8'hFF, 8'hFF, 1'b0, 4'hA);
    apply(8'h00, 8'hC0, 1'b0, 4'h4);
    apply(8'h00, 8'h40, 1'b1, 4'h5);
    apply(8'h00, 8'h81, 1'b0, 4'h6);
    apply(8'h00, 8'h01, 1'b0, 4'h7);
    apply(8'h00, 8'h02, 1'b1, 4'h7);
    apply(8'h12, 8'h34, 1'b1, 4'h3);
    apply(8'hFF, 8'hFF, 1'b1, 4'h0);
    for (int i = 0; i < 2000; i++)
      apply(8'($urandom), 8'($urandom), 1'($urandom), 4'($urandom));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule